// File: doc/BRIEF.md
# Systolic FIR Filter Array

This block is a finite impulse response filter built as a straight chain of identical cells. Each cell holds one coefficient and talks only to the cell before it and the cell after it. Samples enter at the head of the chain and move two registers per cell. Partial sums move one register per cell in the same direction, so each sum meets the right sample in every cell. The finished sum leaves at the tail. All cells multiply and accumulate in parallel. The chain takes at most one new sample per clock, and its storage depends only on the tap count.

Samples arrive on a valid/ready stream and results leave on a valid/ready stream. A sample is taken when `in_valid` and `in_ready` are both high. Every register of the chain advances only on that handshake, so an input gap adds no bubble and does not misalign the chain. A result is handed over when `out_valid` and `out_ready` are both high. While a result waits unread, the chain freezes and refuses input. Coefficients are loaded through a serial shift port that moves values from cell to cell. The shift port can run at any time.

Top module: `sfir_array`

## Requirements
- R1: Let sample n be the n-th sample accepted since reset, with every sample before sample 0 equal to zero. Result n is the sum over taps i = 0..TAPS-1 of w_i·x(n−i), where tap 0 multiplies the newest sample. All values are two's complement signed.
- R2: A cycle with `coef_wr` high shifts `coef_wr_data` into tap 0 and moves each tap's coefficient to the next higher tap. To set w_0..w_{TAPS-1}, write w_{TAPS-1} first and w_0 last.
- R3: The result is ACC_W = DATA_W + COEF_W + ceil(log2 TAPS) bits wide and is exact. This holds even with every sample and every coefficient at −2^(W−1).
- R4: `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R5: After reset, `out_valid` stays low through the first TAPS−1 accepted samples. From then on, each accepted sample makes `out_valid` high in the next cycle, carrying one new result. Results come out in sample order.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values in the next cycle and no sample is accepted.
- R7: After an output handshake in a cycle that accepts no sample, `out_valid` is low in the next cycle.
- R8: Synchronous reset `rst` (active high) sets all samples, partial sums and coefficients to zero. Right after reset, `out_valid` is 0 and `in_ready` is 1.
- R9: A cycle that accepts no sample leaves the chain unchanged. A stream with gaps gives the same results as the same samples sent back to back.
- R10: Tap i of result n uses the coefficient that sits in tap i on the clock edge that accepts sample n+i. A coefficient write in that same cycle takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_wr | input | 1 | Shift one coefficient into the chain |
| coef_wr_data | input | COEF_W | Coefficient value shifted into tap 0 |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken |
| in_data | input | DATA_W | Signed sample |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ACC_W | Signed filter result |

## Verification
Two events can fall in the same cycle: a coefficient shift and a sample acceptance. They are provoked by random coefficient writes at a low rate during a random stream with gaps and stalls. The bench model records the coefficient set held at every acceptance edge and builds each expected result tap by tap from those records, as R10 states. A second pairing is an output handshake together with a new acceptance, which must keep `out_valid` high. A handshake with no new acceptance must drop `out_valid`. Both pairings are judged every cycle against a modelled valid flag.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  function automatic int acc_width(input int data_w, input int coef_w, input int taps);
    return data_w + coef_w + $clog2(taps);
  endfunction

  function automatic int fill_width(input int taps);
    return $clog2(taps + 1);
  endfunction
endpackage

// File: rtl/sfir_cell.sv
module sfir_cell #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 35
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     step,
  input  logic                     coef_we,
  input  logic signed [COEF_W-1:0] coef_in,
  output logic signed [COEF_W-1:0] coef_out,
  input  logic signed [DATA_W-1:0] x_in,
  output logic signed [DATA_W-1:0] x_out,
  input  logic signed [ACC_W-1:0]  s_in,
  output logic signed [ACC_W-1:0]  s_out,
  input  logic                     t_in,
  output logic                     t_out
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] x_near, x_far;
  logic signed [COEF_W-1:0] w_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  sum_q;
  logic                     tag_q;

  assign prod = PROD_W'(x_in) * PROD_W'(w_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_near <= '0;
      x_far  <= '0;
      w_q    <= '0;
      sum_q  <= '0;
      tag_q  <= 1'b0;
    end else begin
      if (coef_we) w_q <= coef_in;
      if (step) begin
        x_near <= x_in;
        x_far  <= x_near;
        sum_q  <= s_in + ACC_W'(prod);
        tag_q  <= t_in;
      end
    end
  end

  assign coef_out = w_q;
  assign x_out    = x_far;
  assign s_out    = sum_q;
  assign t_out    = tag_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (step && (s_in[ACC_W-1] == prod[PROD_W-1])) |=> (sum_q[ACC_W-1] == $past(prod[PROD_W-1]))) // R3
    else $error("partial sum overflowed");

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !coef_we |=> $stable(w_q)) // R2
    else $error("coefficient changed without write");

  AST_SAMPLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(x_near) && $stable(sum_q))) // R9
    else $error("cell moved without step");
endmodule

// File: rtl/sfir_flow.sv
module sfir_flow #(
  parameter int TAPS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic last_tag,
  output logic in_ready,
  output logic out_valid,
  output logic step
);
  localparam int FILL_W = sfir_pkg::fill_width(TAPS);

  logic              fresh_q;
  logic [FILL_W-1:0] fill_q;

  assign out_valid = fresh_q & last_tag;
  assign in_ready  = !out_valid || out_ready;
  assign step      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b0;
      fill_q  <= '0;
    end else begin
      if (step) fresh_q <= 1'b1;
      else if (out_ready) fresh_q <= 1'b0;
      if (step && (fill_q != FILL_W'(TAPS))) fill_q <= fill_q + 1'b1;
    end
  end

  AST_FILL_GATE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fill_q == FILL_W'(TAPS))) // R5
    else $error("result offered before chain filled");

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid) // R7
    else $error("valid persisted after handshake");
endmodule

// File: rtl/sfir_array.sv
module sfir_array #(
  parameter int TAPS   = 5,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int ACC_W = sfir_pkg::acc_width(DATA_W, COEF_W, TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coef_wr,
  input  logic [COEF_W-1:0] coef_wr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_data
);
  logic signed [DATA_W-1:0] x_link [TAPS+1];
  logic signed [COEF_W-1:0] c_link [TAPS+1];
  logic signed [ACC_W-1:0]  s_link [TAPS+1];
  logic                     t_link [TAPS+1];
  logic                     step;

  assign x_link[0] = $signed(in_data);
  assign c_link[0] = $signed(coef_wr_data);
  assign s_link[0] = '0;
  assign t_link[0] = 1'b1;

  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    sfir_cell #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .ACC_W (ACC_W)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .coef_we (coef_wr),
      .coef_in (c_link[j]),
      .coef_out(c_link[j+1]),
      .x_in    (x_link[j]),
      .x_out   (x_link[j+1]),
      .s_in    (s_link[j]),
      .s_out   (s_link[j+1]),
      .t_in    (t_link[j]),
      .t_out   (t_link[j+1])
    );
  end

  sfir_flow #(.TAPS(TAPS)) u_flow (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .last_tag (t_link[TAPS]),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .step     (step)
  );

  assign out_data = s_link[TAPS];

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))) // R6
    else $error("result changed under back-pressure");

  AST_GAP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(x_link[TAPS]) && $stable(s_link[TAPS]))) // R9
    else $error("chain tail moved without acceptance");

  AST_COEF_SHIFT: assert property (@(posedge clk) disable iff (rst)
    coef_wr |=> (c_link[TAPS] == $past(c_link[TAPS-1]))) // R2
    else $error("coefficient did not shift to neighbour");
endmodule

// File: tb/sim_sfir_array.sv
module sim_sfir_array;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS   = 5;
  localparam int DATA_W = 16;
  localparam int COEF_W = 16;
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS);
  localparam int RING   = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              coef_wr = 1'b0;
  logic [COEF_W-1:0] coef_wr_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [ACC_W-1:0]  out_data;

  int checks = 0;
  int failures = 0;

  longint xs   [RING];
  longint snap [RING][TAPS];
  longint mc   [TAPS];
  int     n_acc, n_out;
  bit     exp_valid, hold_prev;
  logic [ACC_W-1:0] prev_data;

  sfir_array #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W)) u0 (
    .clk(clk), .rst(rst), .coef_wr(coef_wr), .coef_wr_data(coef_wr_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_y(input int n);
    longint acc = 0;
    for (int j = 0; j < TAPS; j++)
      if (n - j >= 0) acc += snap[(n + j) % RING][j] * xs[(n - j) % RING];
    return acc;
  endfunction

  function automatic longint sx(input logic [ACC_W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic model_clear();
    n_acc = 0; n_out = 0; exp_valid = 0; hold_prev = 0;
    for (int j = 0; j < TAPS; j++) mc[j] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 0; coef_wr = 0; out_ready = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    #1;
    chk(out_valid == 1'b0, "R8", longint'(out_valid), 0);
    chk(in_ready == 1'b1, "R8", longint'(in_ready), 1);
  endtask

  task automatic cycle(input bit iv, input logic [DATA_W-1:0] d, input bit ordy,
                       input bit cw, input logic [COEF_W-1:0] cd, input string req);
    bit acc, fire;
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy; coef_wr = cw; coef_wr_data = cd;
    #1;
    chk(in_ready == (!out_valid || ordy), "R4", longint'(in_ready), longint'(!out_valid || ordy));
    chk(out_valid == exp_valid, "R5", longint'(out_valid), longint'(exp_valid));
    if (hold_prev)
      chk(out_valid && out_data == prev_data, "R6", sx(out_data), sx(prev_data));
    acc  = iv && in_ready;
    fire = out_valid && ordy;
    if (fire) begin
      chk(sx(out_data) == exp_y(n_out), req, sx(out_data), exp_y(n_out));
      n_out++;
    end
    if (acc) begin
      xs[n_acc % RING] = longint'($signed(d));
      for (int j = 0; j < TAPS; j++) snap[n_acc % RING][j] = mc[j];
      n_acc++;
    end
    if (cw) begin
      for (int j = TAPS - 1; j > 0; j--) mc[j] = mc[j-1];
      mc[0] = longint'($signed(cd));
    end
    if (acc) exp_valid = (n_acc >= TAPS);
    else if (fire) exp_valid = 0;
    hold_prev = out_valid && !ordy;
    prev_data = out_data;
  endtask

  task automatic load(input longint w [TAPS]);
    for (int j = TAPS - 1; j >= 0; j--)
      cycle(0, '0, 1, 1, COEF_W'(w[j]), "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint w [TAPS];
    longint neg [TAPS];
    void'($urandom(32'd2024));
    model_clear();
    do_reset();

    // R2 / R1: impulse response reveals the loaded order
    w = '{3, -2, 5, 7, -1};
    load(w);
    cycle(1, 16'd1, 1, 0, '0, "R2");
    for (int i = 0; i < TAPS + 3; i++) cycle(1, '0, 1, 0, '0, "R2");
    for (int i = 0; i < 6; i++) cycle(1, DATA_W'(i * 100 - 250), 1, 0, '0, "R1");

    // R6: stall with result pending, then drain
    for (int i = 0; i < 4; i++) cycle(1, DATA_W'(i + 9), 0, 0, '0, "R6");
    cycle(0, '0, 1, 0, '0, "R7");
    cycle(0, '0, 1, 0, '0, "R7");

    // R3: full-scale extremes
    do_reset();
    for (int j = 0; j < TAPS; j++) neg[j] = -32768;
    load(neg);
    for (int i = 0; i < 2 * TAPS; i++) cycle(1, 16'h8000, 1, 0, '0, "R3");
    for (int i = 0; i < 2 * TAPS; i++) cycle(1, (i % 2) ? 16'h7FFF : 16'h8000, 1, 0, '0, "R3");

    // R9: random gaps and back-pressure
    do_reset();
    for (int j = 0; j < TAPS; j++) w[j] = longint'($signed(16'($urandom)));
    load(w);
    for (int i = 0; i < 1500; i++)
      cycle(($urandom % 10) < 6, 16'($urandom), ($urandom % 10) < 7, 0, '0, "R9");

    // R10: coefficient writes colliding with sample acceptance
    for (int i = 0; i < 1500; i++)
      cycle(($urandom % 10) < 7, 16'($urandom), ($urandom % 10) < 8,
            ($urandom % 20) == 0, 16'($urandom), "R10");

    // R8: reset mid-stream, then refill from zero history
    do_reset();
    load(w);
    for (int i = 0; i < 40; i++)
      cycle(1, 16'($urandom), ($urandom % 4) != 0, 0, '0, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule